// File: doc/BRIEF.md
# Streaming Histogram Cell Array

This block builds the histogram of one image frame as the pixels stream past. Each beat on the input bus carries a fixed number of pixel values (one, two or four lanes, set by a parameter). The beat moves through a linear pipeline of identical cells. Every cell keeps the counters for a small run of adjacent bin values in flip-flops, so no memory macro is needed. A cell adds to one of its own bins for each lane that carries a value in its range, and it always hands the beat on to the next cell one cycle later. The input never stalls, and every lane of every accepted beat is counted in that same pass.

A frame-start strobe clears the counters and opens the compute phase. A frame-end strobe closes it. The array then waits long enough for the last beat to leave the pipeline. After that it turns its counters into one long shift chain and streams them out, one word per cycle in ascending bin order, with a valid flag and the bin index beside each word. An external memory can write these words in sequence without address conflicts. When the last bin has been sent, the block goes back to idle.

Top module: `hist_cell_array`

## Requirements
- R1: After reset the block is idle, `rd_valid` is 0 and every bin counter holds 0.
- R2: A `frame_start` pulse sampled while idle sets every bin to 0 and starts the compute phase. A `frame_start` pulse during the drain or read phase has no effect.
- R3: In the compute phase, every beat with `pix_valid` high is counted in full, with no stall and no ready signal. Lane i of `pix_data` is bits [i*DATA_W +: DATA_W], and all LANES lanes are counted.
- R4: When several lanes of one beat carry the same value, that bin grows by the number of those lanes, so a collision never loses a count.
- R5: A bin counter stops at 2^CNT_W-1 and never wraps.
- R6: Beats presented while idle, draining or reading are ignored. A `frame_end` pulse outside the compute phase is ignored and starts no read.
- R7: After `frame_end` is sampled in the compute phase, the first output word has `rd_valid` high on the NCELLS+1-th rising edge, counting the edge that sampled `frame_end` as the first. Then exactly 2^DATA_W words follow on consecutive cycles, with `rd_bin` going from 0 upward. After the last word `rd_valid` falls and the block is idle.
- R8: Cell c owns bin values c*BPC to c*BPC+BPC-1. The word sent for bin b equals the number of lane items with value b counted in the frame (saturated as in R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Clears the counters and opens a frame (idle only) |
| frame_end | input | 1 | Closes the frame and starts drain then readout (compute only) |
| pix_valid | input | 1 | The current beat on `pix_data` holds pixels |
| pix_data | input | LANES*DATA_W | LANES pixel values, lane i at bits [i*DATA_W +: DATA_W] |
| rd_valid | output | 1 | A histogram word is on `rd_count` |
| rd_bin | output | DATA_W | Bin index of the current word |
| rd_count | output | CNT_W | Count of the current bin |

## Verification
The same stimulus drives three copies of the array with one, two and four lanes. This separates lane-slicing mistakes from counting mistakes, and the two-lane copy has a narrow counter so that it reaches saturation. An empty frame checks clearing and the read sequence by themselves. Random frames with gaps in `pix_valid` check bin ownership across cells and the drop of idle beats. Beats that repeat one value on all lanes check collision counting, because a design that counts one lane per bin would come up short. Stray beats and strobes sent while idle, draining and reading must leave the streamed words unchanged, and the cycle count from `frame_end` to the first word checks that the drain wait is exact.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_COUNT = 2'd1,
    MODE_DRAIN = 2'd2,
    MODE_READ  = 2'd3
  } hist_mode_e;

endpackage

// File: rtl/hist_cell.sv
module hist_cell #(
  parameter int DATA_W   = 6,
  parameter int LANES    = 4,
  parameter int CNT_W    = 16,
  parameter int BPC      = 4,
  parameter int CELL_IDX = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    shift,
  input  logic                    in_vld,
  input  logic [LANES*DATA_W-1:0] in_pix,
  output logic                    out_vld,
  output logic [LANES*DATA_W-1:0] out_pix,
  input  logic [CNT_W-1:0]        shift_in,
  output logic [CNT_W-1:0]        head
);

  localparam int HIT_W = $clog2(LANES + 1);
  localparam int BASE  = CELL_IDX * BPC;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // number of lanes in a beat whose value equals target
  function automatic logic [HIT_W-1:0] lane_hits(
    input logic [LANES*DATA_W-1:0] pix,
    input logic [DATA_W-1:0]       target
  );
    logic [HIT_W-1:0] n;
    n = '0;
    for (int l = 0; l < LANES; l++) begin
      if (pix[l*DATA_W +: DATA_W] == target) n = n + 1'b1;
    end
    return n;
  endfunction

  // add with clamp at the top of the counter range
  function automatic logic [CNT_W-1:0] sat_add(
    input logic [CNT_W-1:0] cur,
    input logic [HIT_W-1:0] inc
  );
    logic [CNT_W:0] s;
    s = {1'b0, cur} + {{(CNT_W + 1 - HIT_W){1'b0}}, inc};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  logic [CNT_W-1:0] bin_q     [BPC];
  logic [CNT_W-1:0] shift_src [BPC];
  logic [HIT_W-1:0] hits      [BPC];

  always_comb begin
    for (int j = 0; j < BPC; j++) begin
      hits[j]      = in_vld ? lane_hits(in_pix, DATA_W'(BASE + j)) : '0;
      shift_src[j] = (j == BPC - 1) ? shift_in : bin_q[(j + 1) % BPC];
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < BPC; j++) begin
      if (!rst_n || clr)        bin_q[j] <= '0;
      else if (shift)           bin_q[j] <= shift_src[j];
      else if (hits[j] != '0)   bin_q[j] <= sat_add(bin_q[j], hits[j]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_pix <= '0;
    end else begin
      out_vld <= in_vld;
      out_pix <= in_pix;
    end
  end

  assign head = bin_q[0];

  for (genvar j = 0; j < BPC; j++) begin : g_chk
    // R4: one beat adds at most LANES to a bin, and a bin never goes down while counting
    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr) && !$past(shift)) |->
        (bin_q[j] >= $past(bin_q[j]) && (bin_q[j] - $past(bin_q[j])) <= LANES));
    // R5: a full counter stays full
    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bin_q[j]) == CNT_MAX && !$past(clr) && !$past(shift)) |-> bin_q[j] == CNT_MAX);
    // R2: a clear leaves the bin at zero
    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> bin_q[j] == '0);
  end

endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int NCELLS = 16,
  parameter int NBINS  = 64,
  parameter int BIN_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             frame_end,
  output hist_mode_e       mode,
  output logic             clr,
  output logic             accept_en,
  output logic             shift,
  output logic             rd_valid,
  output logic [BIN_W-1:0] rd_bin
);

  localparam int DRN_W = (NCELLS > 1) ? $clog2(NCELLS) : 1;
  localparam logic [DRN_W-1:0] DRN_LAST = DRN_W'(NCELLS - 1);
  localparam logic [BIN_W-1:0] IDX_LAST = BIN_W'(NBINS - 1);

  hist_mode_e       mode_q;
  logic [DRN_W-1:0] drn_q;
  logic [BIN_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      drn_q  <= '0;
      idx_q  <= '0;
    end else begin
      unique case (mode_q)
        MODE_IDLE:  if (frame_start) mode_q <= MODE_COUNT;
        MODE_COUNT: if (frame_end) begin
          mode_q <= MODE_DRAIN;
          drn_q  <= '0;
        end
        MODE_DRAIN: begin
          if (drn_q == DRN_LAST) begin
            mode_q <= MODE_READ;
            idx_q  <= '0;
          end else begin
            drn_q <= drn_q + 1'b1;
          end
        end
        MODE_READ: begin
          if (idx_q == IDX_LAST) mode_q <= MODE_IDLE;
          else                   idx_q  <= idx_q + 1'b1;
        end
        default: mode_q <= MODE_IDLE;
      endcase
    end
  end

  assign mode      = mode_q;
  assign clr       = (mode_q == MODE_IDLE) && frame_start;
  assign accept_en = (mode_q == MODE_COUNT);
  assign shift     = (mode_q == MODE_READ);
  assign rd_valid  = (mode_q == MODE_READ);
  assign rd_bin    = idx_q;

  // R7: the stream starts at bin 0, counts up by one and stops after the last bin
  assert_rd_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> (rd_bin == '0 && $past(mode_q) == MODE_DRAIN));
  assert_rd_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> rd_bin == BIN_W'($past(rd_bin) + 1'b1));
  assert_rd_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_bin == IDX_LAST) |=> (!rd_valid && mode_q == MODE_IDLE));
  // R2: a frame start during drain or read does not reopen counting
  assert_fs_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && (mode_q == MODE_DRAIN || mode_q == MODE_READ)) |=> mode_q != MODE_COUNT);
  // R6: a frame end outside compute starts nothing
  assert_fe_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && mode_q == MODE_IDLE && !frame_start) |=> mode_q == MODE_IDLE);

endmodule

// File: rtl/hist_cell_array.sv
module hist_cell_array
  import hist_pkg::*;
#(
  parameter int DATA_W = 6,
  parameter int LANES  = 4,
  parameter int BPC    = 4,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_start,
  input  logic                    frame_end,
  input  logic                    pix_valid,
  input  logic [LANES*DATA_W-1:0] pix_data,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_bin,
  output logic [CNT_W-1:0]        rd_count
);

  localparam int NBINS  = 1 << DATA_W;
  localparam int NCELLS = NBINS / BPC;
  localparam int PIX_W  = LANES * DATA_W;

  if (NBINS % BPC != 0) begin : g_bad_split
    $error("bins per cell must divide the bin count");
  end

  hist_mode_e mode;
  logic       clr;
  logic       accept_en;
  logic       shift;

  logic             chain_vld  [NCELLS+1];
  logic [PIX_W-1:0] chain_pix  [NCELLS+1];
  logic [CNT_W-1:0] chain_head [NCELLS+1];

  hist_ctrl #(
    .NCELLS (NCELLS),
    .NBINS  (NBINS),
    .BIN_W  (DATA_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .frame_end   (frame_end),
    .mode        (mode),
    .clr         (clr),
    .accept_en   (accept_en),
    .shift       (shift),
    .rd_valid    (rd_valid),
    .rd_bin      (rd_bin)
  );

  assign chain_vld[0]       = pix_valid & accept_en;
  assign chain_pix[0]       = pix_data;
  assign chain_head[NCELLS] = '0;

  for (genvar c = 0; c < NCELLS; c++) begin : g_cell
    hist_cell #(
      .DATA_W   (DATA_W),
      .LANES    (LANES),
      .CNT_W    (CNT_W),
      .BPC      (BPC),
      .CELL_IDX (c)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .shift    (shift),
      .in_vld   (chain_vld[c]),
      .in_pix   (chain_pix[c]),
      .out_vld  (chain_vld[c+1]),
      .out_pix  (chain_pix[c+1]),
      .shift_in (chain_head[c+1]),
      .head     (chain_head[c])
    );
  end

  assign rd_count = chain_head[0];

  // R6/R7: no beat is still travelling the array once readout has begun
  assert_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_READ) |-> !chain_vld[NCELLS]);
  // R6: nothing enters the array outside compute
  assert_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_COUNT) |-> !chain_vld[0]);

endmodule

// File: tb/test_hist_cell_array.sv
`timescale 1ns/1ps
module test_hist_cell_array;

  localparam int DW = 6;
  localparam int NB = 64;
  localparam int NC = 16;

  typedef struct { int bin; int cnt; } word_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs = 1'b0;
  logic fe = 1'b0;
  logic pv = 1'b0;
  logic [4*DW-1:0] pd = '0;

  logic rv4, rv2, rv1;
  logic [DW-1:0] rb4, rb2, rb1;
  logic [15:0] rc4, rc1;
  logic [4:0]  rc2;

  int m4 [NB];
  int m2 [NB];
  int m1 [NB];
  word_t q4[$];
  word_t q2[$];
  word_t q1[$];
  string tag = "R8";
  int checks = 0;
  int fails = 0;
  bit counting = 1'b0;

  always #10 clk = ~clk;

  hist_cell_array #(.DATA_W(DW), .LANES(4), .BPC(4), .CNT_W(16)) i_hist_cell_array (
    .clk(clk), .rst_n(rst_n), .frame_start(fs), .frame_end(fe), .pix_valid(pv),
    .pix_data(pd), .rd_valid(rv4), .rd_bin(rb4), .rd_count(rc4));
  hist_cell_array #(.DATA_W(DW), .LANES(2), .BPC(4), .CNT_W(5)) i_hist_cell_array_k2 (
    .clk(clk), .rst_n(rst_n), .frame_start(fs), .frame_end(fe), .pix_valid(pv),
    .pix_data(pd[2*DW-1:0]), .rd_valid(rv2), .rd_bin(rb2), .rd_count(rc2));
  hist_cell_array #(.DATA_W(DW), .LANES(1), .BPC(4), .CNT_W(16)) i_hist_cell_array_k1 (
    .clk(clk), .rst_n(rst_n), .frame_start(fs), .frame_end(fe), .pix_valid(pv),
    .pix_data(pd[DW-1:0]), .rd_valid(rv1), .rd_bin(rb1), .rd_count(rc1));

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // scoreboard monitors, one per lane count
  always @(negedge clk) begin
    word_t w;
    if (rst_n && rv4) begin
      if (q4.size() == 0) chk("R7", 1, 0, "k4 word beyond the last bin");
      else begin
        w = q4.pop_front();
        chk(tag, int'(rb4), w.bin, "k4 bin index");
        chk(tag, int'(rc4), w.cnt, "k4 count");
      end
    end
  end
  always @(negedge clk) begin
    word_t w;
    if (rst_n && rv2) begin
      if (q2.size() == 0) chk("R7", 1, 0, "k2 word beyond the last bin");
      else begin
        w = q2.pop_front();
        chk(tag, int'(rb2), w.bin, "k2 bin index");
        chk(tag, int'(rc2), w.cnt, "k2 count");
      end
    end
  end
  always @(negedge clk) begin
    word_t w;
    if (rst_n && rv1) begin
      if (q1.size() == 0) chk("R7", 1, 0, "k1 word beyond the last bin");
      else begin
        w = q1.pop_front();
        chk(tag, int'(rb1), w.bin, "k1 bin index");
        chk(tag, int'(rc1), w.cnt, "k1 count");
      end
    end
  end

  // driver: one beat, expected histograms updated for each lane count
  task automatic beat(input logic v, input logic [4*DW-1:0] d);
    pv = v;
    pd = d;
    if (v && counting) begin
      for (int l = 0; l < 4; l++) begin
        int b;
        b = int'(d[l*DW +: DW]);
        m4[b] = (m4[b] < 65535) ? m4[b] + 1 : 65535;
        if (l < 2) m2[b] = (m2[b] < 31) ? m2[b] + 1 : 31;
        if (l < 1) m1[b] = m1[b] + 1;
      end
    end
    @(negedge clk);
    pv = 1'b0;
  endtask

  task automatic start_frame();
    fs = 1'b1;
    for (int b = 0; b < NB; b++) begin
      m4[b] = 0; m2[b] = 0; m1[b] = 0;
    end
    counting = 1'b1;
    @(negedge clk);
    fs = 1'b0;
  endtask

  task automatic end_frame(input bit poke);
    int n;
    fe = 1'b1;
    counting = 1'b0;
    for (int b = 0; b < NB; b++) begin
      q4.push_back('{b, m4[b]});
      q2.push_back('{b, m2[b]});
      q1.push_back('{b, m1[b]});
    end
    @(negedge clk);
    fe = 1'b0;
    n = 1;
    while (!rv4 && n < 200) begin
      pv = 1'b1;                      // R6: beats during drain are dropped
      pd = 24'($urandom);
      @(negedge clk);
      n++;
    end
    pv = 1'b0;
    chk("R7", n, NC + 1, "edges from frame_end to first word");
    for (int i = 0; i < NB + 3; i++) begin
      fs = poke && (i == 10);         // R2: frame_start mid-read ignored
      pv = (i % 3 == 0);              // R6: beats during read are dropped
      pd = 24'($urandom);
      @(negedge clk);
    end
    fs = 1'b0;
    pv = 1'b0;
    chk("R7", q4.size() + q2.size() + q1.size(), 0, "words not delivered");
    chk("R7", int'(rv4) + int'(rv2) + int'(rv1), 0, "rd_valid after last word");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R7 watchdog expired: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", int'(rv4) + int'(rv2) + int'(rv1), 0, "rd_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(rv4) + int'(rv2) + int'(rv1), 0, "rd_valid after reset");

    // R1/R2: empty frame reads all zeros
    tag = "R1";
    start_frame();
    end_frame(1'b0);

    // R6: idle beats and an idle frame_end do nothing; R2: frame_start poke during read
    tag = "R6";
    for (int i = 0; i < 6; i++) beat(1'b1, 24'($urandom));
    fe = 1'b1;
    @(negedge clk);
    fe = 1'b0;
    for (int i = 0; i < NC + 4; i++) begin
      chk("R6", int'(rv4) + int'(rv2) + int'(rv1), 0, "read started by idle frame_end");
      @(negedge clk);
    end
    tag = "R2";
    start_frame();
    for (int i = 0; i < 10; i++) beat(1'b1, {6'(i), 6'(i + 20), 6'(i * 3), 6'(63 - i)});
    end_frame(1'b1);

    // R3/R8: random frame with gaps in pix_valid
    tag = "R3";
    start_frame();
    for (int i = 0; i < 300; i++) beat(($urandom % 4) != 0, 24'($urandom));
    end_frame(1'b0);

    // R4: collisions, all lanes or lane pairs carrying the same value
    tag = "R4";
    start_frame();
    for (int i = 0; i < 20; i++) begin
      logic [5:0] v;
      v = 6'((i % 5) * 13);
      beat(1'b1, {4{v}});
      beat(1'b1, {v, 6'd50, v, 6'd50});
    end
    end_frame(1'b0);

    // R5: saturation of the narrow counter in the two-lane copy
    tag = "R5";
    start_frame();
    for (int i = 0; i < 40; i++) beat(1'b1, {4{6'd7}});
    for (int i = 0; i < 5; i++) beat(1'b1, {6'd1, 6'd2, 6'd3, 6'd4});
    end_frame(1'b0);

    // R8: dense random frame across every cell
    tag = "R8";
    start_frame();
    for (int i = 0; i < 200; i++) beat(1'b1, 24'($urandom));
    end_frame(1'b0);

    summary();
    $finish;
  end

endmodule